// File: doc/BRIEF.md
# FIFO Threshold and DMA Flow-Control Generator

This block watches the fill state of a receive FIFO and of a transmit FIFO and turns it into DMA flow-control requests and interrupt triggers. The receive side reports how many bytes it holds. The transmit side reports how many bytes it holds and its total capacity, and the block derives the free space from those two. Three small configuration registers set the thresholds. A single-cycle write port with a 2-bit select loads them.

A 3-bit block-size code selects each DMA threshold. The code picks a power-of-two byte count, and codes 6 and 7 are unused. The receive request asks the DMA to drain the FIFO once the FIFO holds more bytes than one block. The transmit request asks the DMA to refill the FIFO once a whole block of space is free. A separate word-aligned threshold produces a one-cycle almost-full interrupt when the receive level first rises above it. A byte-granular threshold holds a host interrupt trigger high while enough transmit bytes are waiting for the host. The FIFO storage and the DMA engine are not part of the block.

Top module: `fifo_level_flowctl`

## Requirements
- R1: While `rst` is high, all four outputs are low. Reset leaves both block-size codes at 2 (16 bytes), the almost-full word field at 1 (4 bytes) and the host threshold at 128.
- R2: Block-size code c in 0..5 selects a threshold of 4·2^c bytes: 4, 8, 16, 32, 64 or 128.
- R3: `rx_dma_req` is high when `rx_level` is strictly greater than the receive threshold. A level equal to the threshold gives no request.
- R4: `tx_dma_req` is high when the transmit free space (`tx_capacity - tx_level`) is greater than or equal to the transmit threshold. The free space is taken as 0 when `tx_level` exceeds `tx_capacity`.
- R5: A block-size code of 6 or 7 holds the corresponding DMA request low, whatever the level.
- R6: A write with select 0 loads the receive code from data bits 2:0 and the transmit code from bits 18:16. Every other data bit is ignored.
- R7: A write with select 1 loads a 6-bit word count from data bits 7:2, so the threshold is that count times 4 bytes. `rx_almost_full_irq` pulses for exactly one cycle when `rx_level` goes from not above this threshold to strictly above it. The pulse fires again only after the level has dropped back to or below the threshold.
- R8: A write with select 2 loads an 8-bit host threshold from data bits 7:0. `host_irq_trigger` is high when the threshold is nonzero and `tx_level` is greater than or equal to it. A threshold of 0 never triggers.
- R9: All outputs are registered. An output reflects the levels presented one clock edge earlier. A configuration write is applied at its clock edge, and the outputs use the new value from the following edge on.
- R10: A write with select 3 changes no threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe, one cycle per write |
| cfg_sel | input | 2 | Configuration target: 0 DMA codes, 1 almost-full, 2 host threshold, 3 none |
| cfg_wdata | input | 32 | Configuration write data |
| rx_level | input | CNT_W | Bytes currently held by the receive FIFO |
| tx_level | input | CNT_W | Bytes currently held by the transmit FIFO |
| tx_capacity | input | CNT_W | Total byte capacity of the transmit FIFO |
| rx_dma_req | output | 1 | Receive DMA flow-control request |
| tx_dma_req | output | 1 | Transmit DMA flow-control request |
| rx_almost_full_irq | output | 1 | One-cycle receive almost-full interrupt pulse |
| host_irq_trigger | output | 1 | Host interrupt trigger level |

## Verification
The bench builds the block with `CNT_W = 9`, so the level inputs reach 511. That range covers the largest almost-full threshold of 252 bytes, a 128-byte block with one byte to spare on either side, and transmit levels above the stated capacity, which exercise the free-space clamp. The scoreboard sweeps all eight block-size codes on both sides, testing each exactly at its threshold and one byte past it. It also follows the almost-full pulse through arming, holding and re-arming, and checks that each configuration write changes the outputs only from the second edge after it.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;

    localparam int unsigned CODE_W     = 3;
    localparam int unsigned AF_W       = 6;
    localparam int unsigned HTHR_W     = 8;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned MAX_CODE   = 5;
    localparam int unsigned RX_CODE_LO = 0;
    localparam int unsigned TX_CODE_LO = 16;
    localparam int unsigned AF_LO      = 2;

    typedef logic [CODE_W-1:0] blk_code_t;

    typedef enum logic [1:0] {
        SEL_DMA_BLK   = 2'd0,
        SEL_RX_ALMOST = 2'd1,
        SEL_HOST_THR  = 2'd2,
        SEL_NONE      = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        blk_code_t         rx_code;
        blk_code_t         tx_code;
        logic [AF_W-1:0]   af_words;
        logic [HTHR_W-1:0] host_thr;
    } fc_cfg_t;

    localparam fc_cfg_t CFG_RESET = '{
        rx_code:  3'd2,
        tx_code:  3'd2,
        af_words: 6'd1,
        host_thr: 8'd128
    };

    function automatic logic blk_valid(input blk_code_t c);
        return c <= blk_code_t'(MAX_CODE);
    endfunction

    // Bytes in one DMA block; reserved codes return 0 and are gated by blk_valid.
    function automatic logic [BYTE_W-1:0] blk_bytes(input blk_code_t c);
        logic [BYTE_W-1:0] b;
        b = '0;
        if (blk_valid(c)) b = BYTE_W'(4) << c;
        return b;
    endfunction

endpackage

// File: rtl/flowctl_cfg_regs.sv
module flowctl_cfg_regs
    import flowctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  sel,
    input  logic [31:0] wdata,
    output fc_cfg_t     cfg
);

    cfg_sel_e sel_e;
    logic     unused_wdata_bits;

    assign sel_e             = cfg_sel_e'(sel);
    assign unused_wdata_bits = ^{wdata[31:TX_CODE_LO+CODE_W], wdata[TX_CODE_LO-1:BYTE_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (wr_en) begin
            case (sel_e)
                SEL_DMA_BLK: begin
                    cfg.rx_code <= wdata[RX_CODE_LO +: CODE_W];
                    cfg.tx_code <= wdata[TX_CODE_LO +: CODE_W];
                end
                SEL_RX_ALMOST: cfg.af_words <= wdata[AF_LO +: AF_W];
                SEL_HOST_THR:  cfg.host_thr <= wdata[0 +: HTHR_W];
                default:       ;
            endcase
        end
    end

endmodule

// File: rtl/flowctl_dma_cmp.sv
module flowctl_dma_cmp
    import flowctl_pkg::*;
#(
    parameter int unsigned CNT_W     = 11,
    parameter bit          FILL_SIDE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  blk_code_t        code,
    input  logic [CNT_W-1:0] amount,
    output logic             req
);

    localparam int unsigned CMP_W = (CNT_W > BYTE_W) ? CNT_W : BYTE_W;

    logic [CMP_W-1:0] amt_x;
    logic [CMP_W-1:0] thr_x;
    logic             hit;

    assign amt_x = CMP_W'(amount);
    assign thr_x = CMP_W'(blk_bytes(code));

    generate
        if (FILL_SIDE) begin : g_drain_rule
            // Receive side: request once more than one block is buffered.
            assign hit = amt_x > thr_x;
        end else begin : g_space_rule
            // Transmit side: request once a whole block of room is free.
            assign hit = amt_x >= thr_x;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= hit && blk_valid(code);
    end

endmodule

// File: rtl/flowctl_irq_gen.sv
module flowctl_irq_gen
    import flowctl_pkg::*;
#(
    parameter int unsigned CNT_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic [CNT_W-1:0]  tx_level,
    input  logic [AF_W-1:0]   af_words,
    input  logic [HTHR_W-1:0] host_thr,
    output logic              af_pulse,
    output logic              host_trig
);

    localparam int unsigned CMP_W = (CNT_W > BYTE_W) ? CNT_W : BYTE_W;

    logic [CMP_W-1:0] af_thr_x;
    logic [CMP_W-1:0] host_thr_x;
    logic             above_now;
    logic             above_q;

    assign af_thr_x   = CMP_W'({af_words, 2'b00});
    assign host_thr_x = CMP_W'(host_thr);
    assign above_now  = CMP_W'(rx_level) > af_thr_x;

    always_ff @(posedge clk) begin
        if (rst) begin
            above_q   <= 1'b0;
            af_pulse  <= 1'b0;
            host_trig <= 1'b0;
        end else begin
            above_q   <= above_now;
            af_pulse  <= above_now && !above_q;
            host_trig <= (host_thr != '0) && (CMP_W'(tx_level) >= host_thr_x);
        end
    end

endmodule

// File: rtl/fifo_level_flowctl.sv
module fifo_level_flowctl
    import flowctl_pkg::*;
#(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr_en,
    input  logic [1:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] tx_level,
    input  logic [CNT_W-1:0] tx_capacity,
    output logic             rx_dma_req,
    output logic             tx_dma_req,
    output logic             rx_almost_full_irq,
    output logic             host_irq_trigger
);

    fc_cfg_t          cfg;
    logic [CNT_W-1:0] tx_free;

    // Free space is clamped to zero if the reported level exceeds capacity.
    assign tx_free = (tx_level > tx_capacity) ? '0 : (tx_capacity - tx_level);

    flowctl_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cfg_wr_en),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    flowctl_dma_cmp #(.CNT_W(CNT_W), .FILL_SIDE(1'b1)) u_rx_cmp (
        .clk    (clk),
        .rst    (rst),
        .code   (cfg.rx_code),
        .amount (rx_level),
        .req    (rx_dma_req)
    );

    flowctl_dma_cmp #(.CNT_W(CNT_W), .FILL_SIDE(1'b0)) u_tx_cmp (
        .clk    (clk),
        .rst    (rst),
        .code   (cfg.tx_code),
        .amount (tx_free),
        .req    (tx_dma_req)
    );

    flowctl_irq_gen #(.CNT_W(CNT_W)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .rx_level  (rx_level),
        .tx_level  (tx_level),
        .af_words  (cfg.af_words),
        .host_thr  (cfg.host_thr),
        .af_pulse  (rx_almost_full_irq),
        .host_trig (host_irq_trigger)
    );

endmodule

// File: rtl/flowctl_checker.sv
module flowctl_checker #(
    parameter int unsigned CNT_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] rx_level,
    input logic [CNT_W-1:0] tx_level,
    input logic [CNT_W-1:0] tx_capacity,
    input logic             rx_dma_req,
    input logic             tx_dma_req,
    input logic             rx_almost_full_irq,
    input logic             host_irq_trigger
);

    logic [CNT_W-1:0] prev_rx;
    logic [CNT_W-1:0] prev_txl;
    logic [CNT_W-1:0] prev_cap;
    logic [CNT_W:0]   prev_txl_plus4;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_rx  <= '0;
            prev_txl <= '0;
            prev_cap <= '0;
        end else begin
            prev_rx  <= rx_level;
            prev_txl <= tx_level;
            prev_cap <= tx_capacity;
        end
    end

    assign prev_txl_plus4 = {1'b0, prev_txl} + (CNT_W+1)'(4);

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!rx_dma_req && !tx_dma_req && !rx_almost_full_irq && !host_irq_trigger));

    p_rx_req_floor_r3: assert property (@(posedge clk) disable iff (rst)
        rx_dma_req |-> (prev_rx > CNT_W'(4)));

    p_tx_req_floor_r4: assert property (@(posedge clk) disable iff (rst)
        tx_dma_req |-> ({1'b0, prev_cap} >= prev_txl_plus4));

    p_af_single_r7: assert property (@(posedge clk) disable iff (rst)
        rx_almost_full_irq |=> !rx_almost_full_irq);

    p_af_needs_level_r7: assert property (@(posedge clk) disable iff (rst)
        rx_almost_full_irq |-> (prev_rx != '0));

    p_hirq_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        host_irq_trigger |-> (prev_txl != '0));

endmodule

bind fifo_level_flowctl flowctl_checker #(.CNT_W(CNT_W)) u_flowctl_chk (
    .clk                (clk),
    .rst                (rst),
    .rx_level           (rx_level),
    .tx_level           (tx_level),
    .tx_capacity        (tx_capacity),
    .rx_dma_req         (rx_dma_req),
    .tx_dma_req         (tx_dma_req),
    .rx_almost_full_irq (rx_almost_full_irq),
    .host_irq_trigger   (host_irq_trigger)
);

// File: tb/test_fifo_level_flowctl.sv
`timescale 1ns/1ps
module test_fifo_level_flowctl;

    localparam int CNT_W = 9;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_wr_en = 1'b0;
    logic [1:0]       cfg_sel = 2'd0;
    logic [31:0]      cfg_wdata = '0;
    logic [CNT_W-1:0] rx_level = '0;
    logic [CNT_W-1:0] tx_level = '0;
    logic [CNT_W-1:0] tx_capacity = '0;
    logic             rx_dma_req, tx_dma_req, rx_almost_full_irq, host_irq_trigger;

    always #2.5 clk = ~clk;

    fifo_level_flowctl #(.CNT_W(CNT_W)) i_fifo_level_flowctl (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rx_level(rx_level), .tx_level(tx_level),
        .tx_capacity(tx_capacity), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
        .rx_almost_full_irq(rx_almost_full_irq), .host_irq_trigger(host_irq_trigger)
    );

    typedef struct {
        string tag;
        bit    rxr;
        bit    txr;
        bit    af;
        bit    hi;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    bit   finished = 0;

    // Bench-side view of the thresholds, following the written requirements.
    int m_rx_code = 2, m_tx_code = 2, m_af = 1, m_host = 128;
    bit m_above = 0;

    function automatic int blk(input int c);
        return (c <= 5) ? (4 << c) : -1;
    endfunction

    task automatic check(input string what, input string tag, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic step(input int rx, input int txl, input int cap, input bit wr,
                        input int sel, input logic [31:0] wd, input string tag);
        exp_t e;
        int   free;
        bit   above;
        @(negedge clk);
        rx_level    = CNT_W'(rx);
        tx_level    = CNT_W'(txl);
        tx_capacity = CNT_W'(cap);
        cfg_wr_en   = wr;
        cfg_sel     = 2'(sel);
        cfg_wdata   = wd;
        free  = (txl > cap) ? 0 : cap - txl;
        above = rx > m_af * 4;
        e.tag = tag;
        e.rxr = (blk(m_rx_code) > 0) && (rx > blk(m_rx_code));
        e.txr = (blk(m_tx_code) > 0) && (free >= blk(m_tx_code));
        e.af  = above && !m_above;
        e.hi  = (m_host != 0) && (txl >= m_host);
        m_above = above;
        if (wr) begin
            case (sel)
                0: begin m_rx_code = int'(wd[2:0]); m_tx_code = int'(wd[18:16]); end
                1: m_af = int'(wd[7:2]);
                2: m_host = int'(wd[7:0]);
                default: ;
            endcase
        end
        @(posedge clk);
        q.push_back(e);
    endtask

    task automatic idle(input int rx, input int txl, input int cap, input string tag);
        step(rx, txl, cap, 1'b0, 0, 32'h0, tag);
    endtask

    // Monitor: pops one expectation per cycle and compares at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check("rx_dma_req",         e.tag, rx_dma_req,         e.rxr);
                check("tx_dma_req",         e.tag, tx_dma_req,         e.txr);
                check("rx_almost_full_irq", e.tag, rx_almost_full_irq, e.af);
                check("host_irq_trigger",   e.tag, host_irq_trigger,   e.hi);
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("rx_dma_req in reset",         "R1", rx_dma_req, 1'b0);
        check("tx_dma_req in reset",         "R1", tx_dma_req, 1'b0);
        check("rx_almost_full_irq in reset", "R1", rx_almost_full_irq, 1'b0);
        check("host_irq_trigger in reset",   "R1", host_irq_trigger, 1'b0);
        rst = 1'b0;

        // R1/R3/R4/R7/R8 with reset thresholds (16, 16, 4, 128).
        idle(4,   48, 64,  "R1_r7_at_af_thr");
        idle(16,  48, 64,  "R1_r3_equal_r4_equal_r7_pulse");
        idle(17,  49, 64,  "R3_above_r4_short_r7_hold");
        idle(0,   127, 128, "R7_rearm_r8_below");
        idle(5,   128, 128, "R7_second_pulse_r8_at_thr");

        // R2/R5/R6: sweep every code with junk in the unused data bits.
        for (int c = 0; c < 8; c++) begin
            logic [31:0] wd;
            int b;
            wd = 32'hFFF8_FFF8 | 32'(c) | (32'(c) << 16);
            b  = (c <= 5) ? (4 << c) : 4;
            step(0, 0, 0, 1'b1, 0, wd, "R6_write_r9_old_cfg");
            idle(b,     0, 0, "R2_rx_at_thr_r5");
            idle(b + 1, 0, 0, "R2_rx_past_thr_r5");
            idle(0, 200 - b,     200, "R2_tx_free_eq_r5");
            idle(0, 200 - b + 1, 200, "R2_tx_free_short_r5");
            idle(300, 0, 200, "R5_r3_r4_large");
        end

        // R4: level above capacity clamps free space to zero (code 0 = 4 bytes).
        step(0, 0, 0, 1'b1, 0, 32'h0000_0000, "R6_write_code0");
        idle(0, 150, 100, "R4_clamp");
        idle(0, 96,  100, "R4_four_free");

        // R7: almost-full word field, low data bits ignored: 0x23 -> 8 words = 32 bytes.
        idle(0, 0, 0, "R7_clear");
        step(0, 0, 0, 1'b1, 1, 32'hFFFF_FF23, "R7_write");
        idle(32, 0, 0, "R7_at_32");
        idle(33, 0, 0, "R7_pulse_33");
        idle(40, 0, 0, "R7_hold");
        idle(32, 0, 0, "R7_drop_to_thr");
        idle(33, 0, 0, "R7_repulse");
        step(0, 0, 0, 1'b1, 1, 32'h0000_00FC, "R7_write_max");
        idle(252, 0, 0, "R7_at_252");
        idle(253, 0, 0, "R7_pulse_253");

        // R8/R9: host threshold 10, write takes effect from the second edge.
        step(0, 10, 300, 1'b1, 2, 32'hABCD_EF0A, "R8_write_r9_old_128");
        idle(0, 9,  300, "R8_below");
        idle(0, 10, 300, "R8_at");
        step(0, 10, 300, 1'b1, 3, 32'h0000_00FF, "R10_write_none");
        idle(0, 10, 300, "R10_host_unchanged");
        idle(300, 0, 300, "R10_rx_code_unchanged");
        step(0, 500, 300, 1'b1, 2, 32'h0000_0000, "R8_write_zero");
        idle(0, 500, 300, "R8_zero_never");
        idle(0, 0, 0, "R8_drain");

        @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule